// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Bank with Overflow Interrupt

This block holds a bank of programmable 64-bit event counters for a processor core. Each counter advances by one when the core sends an increment pulse on that counter's lane. A pulse has no effect when any of the following holds:

- the counter is switched off in a global inhibit vector;
- the counter is missing from the availability mask;
- the counter is one of the three reserved fixed slots;
- the counter's own privilege-inhibit bit matches the current privilege level and virtualization state.

The counting width is selectable. In full mode each counter is one 64-bit register. In split mode each counter is a pair of 32-bit words. When a counter wraps, it sets a sticky overflow flag. The first wrap after that flag is cleared also raises a shared interrupt request, which stays high until it is acknowledged.

Software reaches the counters through a single write port. A write selects a counter and one of three targets: the low word, the high word, or the configuration. The configuration holds the five privilege-inhibit bits and the sticky flag.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset every counter value, every inhibit field, every sticky flag and `irq_pend` are zero.
- R2: With `split_mode` low, an accepted pulse raises a counter value by exactly one, visible at the next clock edge.
- R3: A pulse is ignored when the counter's bit in `glob_inh` is set, when its bit in `avail_mask` is clear, or when its index is 0, 1 or 2.
- R4: Privilege is encoded user=0, supervisor=1, machine=3. Inhibit bits are laid out as bit0 machine, bit1 supervisor, bit2 user, bit3 virtual-supervisor, bit4 virtual-user. With `virt_on` low, the bit matching the current level blocks counting. In machine mode bit0 applies whatever `virt_on` is. Code 2 never blocks.
- R5: With `virt_on` high, supervisor mode is blocked only by bit3 and user mode only by bit4, and bits 1 and 2 have no effect.
- R6: With `split_mode` low, an accepted pulse on an all-ones counter yields zero and sets that counter's sticky flag.
- R7: With `split_mode` high, only the low word advances while it is below all-ones. When the low word is all-ones, the high word advances and the low word stays all-ones. When both words are all-ones, both clear and the sticky flag is set.
- R8: A wrap raises `irq_pend` on the next edge only if the counter's sticky flag was clear before the wrap. `irq_pend` then holds until `irq_ack`, and a new raise in the same cycle as `irq_ack` wins.
- R9: The write kind is 0 for the low word, 1 for the high word, and 2 for the configuration, which takes `wr_data[4:0]` as the inhibit bits and `wr_data[5]` as the sticky flag. A write to a counter takes precedence over a pulse to that same counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| virt_on | input | 1 | Virtualization active |
| split_mode | input | 1 | 1 selects low/high 32-bit counting |
| avail_mask | input | NCTR | Counters present |
| glob_inh | input | NCTR | Global per-counter inhibit |
| inc_pulse | input | NCTR | One increment pulse per counter |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDXW | Counter selected by a write |
| wr_kind | input | 2 | 0 low word, 1 high word, 2 configuration |
| wr_data | input | CW/2 | Write data |
| irq_ack | input | 1 | Clears the pending interrupt |
| cnt_value | output | NCTR*CW | All counter values, counter i at [i*CW +: CW] |
| ovf_flag | output | NCTR | Sticky overflow flags |
| irq_pend | output | 1 | Local overflow interrupt pending |

## Verification
The hardest states to reach from the ports are the wrap points, because counting up to all-ones one pulse at a time would take far too long. The stimulus therefore loads each word through the write port to one step below the boundary, or exactly at it, and then sends a single pulse. This is how the bench reaches the 64-bit wrap, the split-mode case where the low word stays put while the high word advances, and the double all-ones clear. It also reaches a second wrap with the sticky flag still set, which must not raise the interrupt again. The privilege and virtualization combinations are walked from a table, each entry preloading the inhibit bits and expecting either one count or none.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int unsigned FIRST_PROG = 3;
  localparam int unsigned INH_W      = 5;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_MACH  = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    WK_LO  = 2'd0,
    WK_HI  = 2'd1,
    WK_CFG = 2'd2
  } wr_kind_e;

  localparam int unsigned INH_M  = 0;
  localparam int unsigned INH_S  = 1;
  localparam int unsigned INH_U  = 2;
  localparam int unsigned INH_VS = 3;
  localparam int unsigned INH_VU = 4;
  localparam int unsigned CFG_STICKY = 5;
endpackage

// File: rtl/lvl_filter.sv
module lvl_filter
  import evt_ctr_pkg::*;
(
  input  logic [1:0]       lvl,
  input  logic             virt_on,
  input  logic [INH_W-1:0] inh,
  output logic             blocked
);
  always_comb begin
    blocked = 1'b0;
    unique case (lvl)
      LVL_MACH:  blocked = inh[INH_M];
      LVL_SUPER: blocked = virt_on ? inh[INH_VS] : inh[INH_S];
      LVL_USER:  blocked = virt_on ? inh[INH_VU] : inh[INH_U];
      default:   blocked = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
  import evt_ctr_pkg::*;
#(
  parameter int unsigned CW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_mode,
  input  logic             inc_ok,
  input  logic             wr_hit,
  input  logic [1:0]       wr_kind,
  input  logic [CW/2-1:0]  wr_data,
  output logic [CW-1:0]    val,
  output logic [INH_W-1:0] inh,
  output logic             sticky,
  output logic             new_ovf
);
  localparam int unsigned HW = CW / 2;

  logic [CW-1:0]    val_q, val_d;
  logic [INH_W-1:0] inh_q, inh_d;
  logic             stk_q, stk_d;
  logic             wrap;
  logic             lo_full, hi_full;

  assign lo_full = &val_q[HW-1:0];
  assign hi_full = &val_q[CW-1:HW];

  always_comb begin
    val_d = val_q;
    inh_d = inh_q;
    stk_d = stk_q;
    wrap  = 1'b0;
    if (wr_hit) begin
      unique case (wr_kind_e'(wr_kind))
        WK_LO:  val_d[HW-1:0]  = wr_data;
        WK_HI:  val_d[CW-1:HW] = wr_data;
        WK_CFG: begin
          inh_d = wr_data[INH_W-1:0];
          stk_d = wr_data[CFG_STICKY];
        end
        default: ;
      endcase
    end else if (inc_ok) begin
      if (!split_mode) begin
        if (lo_full && hi_full) begin
          val_d = '0;
          wrap  = 1'b1;
        end else begin
          val_d = val_q + CW'(1);
        end
      end else begin
        if (!lo_full) begin
          val_d[HW-1:0] = val_q[HW-1:0] + HW'(1);
        end else if (!hi_full) begin
          val_d[CW-1:HW] = val_q[CW-1:HW] + HW'(1);
        end else begin
          val_d = '0;
          wrap  = 1'b1;
        end
      end
    end
    if (wrap) stk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      inh_q <= '0;
      stk_q <= 1'b0;
    end else begin
      val_q <= val_d;
      inh_q <= inh_d;
      stk_q <= stk_d;
    end
  end

  assign val     = val_q;
  assign inh     = inh_q;
  assign sticky  = stk_q;
  assign new_ovf = wrap & ~stk_q;

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_ok && !wr_hit) |=> $stable(val_q));

  assert_wrap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ok && !wr_hit && !split_mode && (&val_q)) |=> (stk_q && val_q == '0));

  assert_split_lo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ok && !wr_hit && split_mode && lo_full && !hi_full) |=> (&val_q[HW-1:0]));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_kind == WK_LO) |=> (val_q[HW-1:0] == $past(wr_data)));
endmodule

// File: rtl/irq_collect.sv
module irq_collect #(
  parameter int unsigned NCTR = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTR-1:0] new_ovf,
  input  logic            irq_ack,
  output logic            irq_pend
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (irq_ack)  pend_d = 1'b0;
    if (|new_ovf) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq_pend = pend_q;

  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_ovf) |=> pend_q);

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !irq_ack) |=> pend_q);
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NCTR = 8,
  parameter int unsigned CW   = 64,
  localparam int unsigned IDXW = $clog2(NCTR),
  localparam int unsigned HW   = CW / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv_lvl,
  input  logic               virt_on,
  input  logic               split_mode,
  input  logic [NCTR-1:0]    avail_mask,
  input  logic [NCTR-1:0]    glob_inh,
  input  logic [NCTR-1:0]    inc_pulse,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [1:0]         wr_kind,
  input  logic [HW-1:0]      wr_data,
  input  logic               irq_ack,
  output logic [NCTR*CW-1:0] cnt_value,
  output logic [NCTR-1:0]    ovf_flag,
  output logic               irq_pend
);
  logic [NCTR-1:0] new_ovf;
  logic [NCTR-1:0] blocked;
  logic [NCTR-1:0] inc_ok;
  logic [NCTR-1:0] wr_hit;

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    localparam bit ELIG = (i >= FIRST_PROG);
    logic [INH_W-1:0] inh_i;
    logic [CW-1:0]    val_i;

    lvl_filter u_filt (
      .lvl     (priv_lvl),
      .virt_on (virt_on),
      .inh     (inh_i),
      .blocked (blocked[i])
    );

    assign wr_hit[i] = wr_en && (wr_idx == IDXW'(i));
    assign inc_ok[i] = ELIG && inc_pulse[i] && avail_mask[i] &&
                       !glob_inh[i] && !blocked[i];

    ctr_slice #(.CW(CW)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .split_mode (split_mode),
      .inc_ok     (inc_ok[i]),
      .wr_hit     (wr_hit[i]),
      .wr_kind    (wr_kind),
      .wr_data    (wr_data),
      .val        (val_i),
      .inh        (inh_i),
      .sticky     (ovf_flag[i]),
      .new_ovf    (new_ovf[i])
    );

    assign cnt_value[i*CW +: CW] = val_i;

    if (!ELIG) begin : g_fixed
      assert_fixed_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit[i]) |=> $stable(val_i));
    end
  end

  irq_collect #(.NCTR(NCTR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_ovf  (new_ovf),
    .irq_ack  (irq_ack),
    .irq_pend (irq_pend)
  );

  assert_onehot_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
endmodule

// File: tb/sim_evt_ctr_bank.sv
module sim_evt_ctr_bank;
  localparam int NCTR = 8;
  localparam int CW   = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] priv_lvl;
  logic virt_on, split_mode, wr_en, irq_ack;
  logic [NCTR-1:0] avail_mask, glob_inh, inc_pulse;
  logic [2:0] wr_idx;
  logic [1:0] wr_kind;
  logic [31:0] wr_data;
  logic [NCTR*CW-1:0] cnt_value;
  logic [NCTR-1:0] ovf_flag;
  logic irq_pend;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  evt_ctr_bank u0 (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .virt_on(virt_on),
    .split_mode(split_mode), .avail_mask(avail_mask), .glob_inh(glob_inh),
    .inc_pulse(inc_pulse), .wr_en(wr_en), .wr_idx(wr_idx), .wr_kind(wr_kind),
    .wr_data(wr_data), .irq_ack(irq_ack), .cnt_value(cnt_value),
    .ovf_flag(ovf_flag), .irq_pend(irq_pend)
  );

  // entry: {lvl[1:0], virt, inh[4:0], expect_count}
  localparam logic [8:0] VEC [12] = '{
    {2'd3, 1'b0, 5'b00001, 1'b0},  // R4 machine blocked
    {2'd3, 1'b0, 5'b11110, 1'b1},  // R4 machine counts
    {2'd1, 1'b0, 5'b00010, 1'b0},  // R4 supervisor blocked
    {2'd1, 1'b0, 5'b11101, 1'b1},  // R4
    {2'd0, 1'b0, 5'b00100, 1'b0},  // R4 user blocked
    {2'd0, 1'b0, 5'b11011, 1'b1},  // R4
    {2'd1, 1'b1, 5'b01000, 1'b0},  // R5 virtual supervisor blocked
    {2'd1, 1'b1, 5'b10111, 1'b1},  // R5 plain S bit ignored
    {2'd0, 1'b1, 5'b10000, 1'b0},  // R5 virtual user blocked
    {2'd0, 1'b1, 5'b01111, 1'b1},  // R5 plain U bit ignored
    {2'd3, 1'b1, 5'b11110, 1'b1},  // R4 machine ignores virt
    {2'd2, 1'b0, 5'b11111, 1'b1}   // R4 code 2 never blocks
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] cval(input int idx);
    return cnt_value[idx*CW +: CW];
  endfunction

  task automatic wr(input int idx, input logic [1:0] kind, input logic [31:0] d, input bit pulse);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_kind = kind; wr_data = d;
    inc_pulse = pulse ? NCTR'(1) << idx : '0;
    @(negedge clk);
    wr_en = 1'b0; inc_pulse = '0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    inc_pulse = NCTR'(1) << idx;
    @(negedge clk);
    inc_pulse = '0;
  endtask

  task automatic load(input int idx, input logic [31:0] hi, input logic [31:0] lo);
    wr(idx, 2'd0, lo, 1'b0);
    wr(idx, 2'd1, hi, 1'b0);
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; priv_lvl = 2'd3; virt_on = 1'b0; split_mode = 1'b0;
    avail_mask = '1; glob_inh = '0; inc_pulse = '0; wr_en = 1'b0;
    wr_idx = '0; wr_kind = '0; wr_data = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 values", 64'(|cnt_value), 64'd0);
    check("R1 sticky", 64'(ovf_flag), 64'd0);
    check("R1 irq", 64'(irq_pend), 64'd0);

    // R4 / R5 table on counter 3
    for (int k = 0; k < 12; k++) begin
      logic [8:0] v;
      v = VEC[k];
      wr(3, 2'd2, {26'd0, 1'b0, v[5:1]}, 1'b0);
      load(3, 32'd0, 32'd0);
      @(negedge clk);
      priv_lvl = v[8:7]; virt_on = v[6];
      pulse(3);
      check($sformatf("R4/R5 vector %0d", k), cval(3), 64'(v[0]));
    end
    priv_lvl = 2'd3; virt_on = 1'b0;

    // R2 three pulses on counter 4
    pulse(4); pulse(4); pulse(4);
    check("R2 count", cval(4), 64'd3);
    load(4, 32'h0000_0001, 32'hFFFF_FFFF);
    pulse(4);
    check("R2 carry", cval(4), 64'h2_0000_0000);

    // R3 global inhibit, unavailable, fixed slot
    load(4, 32'd0, 32'd7);
    @(negedge clk); glob_inh = 8'h10;
    pulse(4);
    check("R3 global inhibit", cval(4), 64'd7);
    @(negedge clk); glob_inh = '0; avail_mask = 8'hDF;
    pulse(5);
    check("R3 unavailable", cval(5), 64'd0);
    @(negedge clk); avail_mask = '1;
    pulse(2);
    check("R3 fixed slot", cval(2), 64'd0);

    // R6 64-bit wrap
    load(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    pulse(4);
    check("R6 wrap value", cval(4), 64'd0);
    check("R6 sticky", 64'(ovf_flag[4]), 64'd1);
    check("R8 irq raised", 64'(irq_pend), 64'd1);
    @(negedge clk);
    check("R8 irq held", 64'(irq_pend), 64'd1);
    ack();
    check("R8 irq acked", 64'(irq_pend), 64'd0);

    // R8 second wrap with sticky set: no new irq
    load(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    pulse(4);
    check("R8 no re-raise", 64'(irq_pend), 64'd0);
    // clear sticky, wrap again, ack in the same cycle
    wr(4, 2'd2, 32'd0, 1'b0);
    check("R9 sticky cleared", 64'(ovf_flag[4]), 64'd0);
    load(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    @(negedge clk);
    irq_ack = 1'b1; inc_pulse = 8'h10;
    @(negedge clk);
    irq_ack = 1'b0; inc_pulse = '0;
    check("R8 raise beats ack", 64'(irq_pend), 64'd1);
    ack();

    // R7 split mode on counter 6
    @(negedge clk); split_mode = 1'b1;
    load(6, 32'd5, 32'hFFFF_FFFE);
    pulse(6);
    check("R7 lo advances", cval(6), {32'd5, 32'hFFFF_FFFF});
    pulse(6);
    check("R7 hi advances lo holds", cval(6), {32'd6, 32'hFFFF_FFFF});
    wr(6, 2'd1, 32'hFFFF_FFFF, 1'b0);
    pulse(6);
    check("R7 double clear", cval(6), 64'd0);
    check("R7 sticky", 64'(ovf_flag[6]), 64'd1);
    check("R7 irq", 64'(irq_pend), 64'd1);
    ack();
    @(negedge clk); split_mode = 1'b0;

    // R9 write beats same-cycle pulse
    load(4, 32'd0, 32'd3);
    wr(4, 2'd0, 32'h10, 1'b1);
    check("R9 write wins", cval(4), 64'h10);
    wr(4, 2'd2, 32'h0000_001F, 1'b1);
    check("R9 cfg write blocks pulse", cval(4), 64'h10);
    pulse(4);
    check("R9 inhibit bits written", cval(4), 64'h10);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule